// File: doc/BRIEF.md
# Predicated Dual-Slot Issue Gate

This block keeps the predicate state of a two-slot wide-issue datapath and decides, slot by slot, whether the operation presented in that slot is allowed to commit. Each slot names one guard predicate. The slot's operation commits only when it is valid and that guard bit is set. A slot whose guard is clear is squashed: it still counts as issued, so pipeline timing is unchanged, but its write enable is held low.

Either slot can also carry a compare operation. A compare tests a signed register operand against zero and writes the outcome, set or cleared, into a named predicate bit. The compare result is registered once. It is then written into the predicate file one cycle later, and a bypass path lets the very next instruction be gated by it without a stall. Predicate 0 always reads as one, so an unguarded operation names predicate 0. Arithmetic, register data paths and branching sit outside this block.

Top module: `pred_issue_gate`

## Requirements
- R1: After reset, predicate 0 reads 1 and predicates 1 to 31 read 0.
- R2: In each slot, `slot_commit` equals `op_valid` AND the guard bit selected by that slot's 5-bit index. `slot_wr_en` equals `op_wreq` AND `slot_commit`. Both are combinational in the same cycle.
- R3: `slot_issued` follows `op_valid` whether or not the guard is set. A valid slot with a clear guard shows issued=1, commit=0 and wr_en=0.
- R4: The compare code on `cmp_op` (2 bits per slot) has these meanings: 0 is true when the operand is negative, 1 when it is zero or positive, 2 when it is zero, 3 when it is nonzero. The operand is read as 32-bit two's complement. A committed true compare sets the bit at `cmp_dst`.
- R5: A committed compare whose condition is false clears the bit at `cmp_dst`, even if that bit was set before.
- R6: A predicate written by a compare in cycle t gates, and shows on `guard_val`, any slot in cycle t+1. There is no stall cycle.
- R7: A compare in a slot that is not committed changes no predicate. This covers a slot that is invalid and a slot whose guard is clear.
- R8: When both slots commit compares to the same bit in one cycle, the value from slot 1 is kept.
- R9: A compare that targets predicate 0 has no effect. Predicate 0 keeps reading 1.
- R10: Two committed compares to different bits in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 2 | Per-slot operation valid |
| op_wreq | input | 2 | Per-slot write-enable request |
| op_pidx | input | 10 | Per-slot guard index, 5 bits each, slot 0 in the low bits |
| cmp_en | input | 2 | Per-slot flag marking the operation as a compare |
| cmp_op | input | 4 | Per-slot compare code, 2 bits each |
| cmp_dst | input | 10 | Per-slot destination predicate index, 5 bits each |
| cmp_opnd | input | 64 | Per-slot signed operand, 32 bits each |
| slot_issued | output | 2 | Slot counted as issued |
| slot_commit | output | 2 | Slot operation may commit |
| slot_wr_en | output | 2 | Gated write enable |
| guard_val | output | 2 | Bypassed value of each slot's guard predicate |

## Verification
The bench goes after the most negative operand, the largest positive operand and zero under every compare code. If the sign or zero test were wrong, the bit read back in the next cycle would be wrong. Before every compare, the target bit is preloaded with the opposite of the expected result. A design that only set bits, or that let a squashed compare write, is therefore caught. Back-to-back chains check that the bypass path works, since a design without it would gate the following slot on stale state. Same-bit conflicts between the two slots, writes aimed at predicate 0, and a long pseudo-random run against an arithmetic model cover slot priority and the hardwired bit.

// File: rtl/pig_pkg.sv
`timescale 1ns/1ps
package pig_pkg;
  // Compare codes: the test applied to a signed operand.
  typedef enum logic [1:0] {
    CMP_LTZ = 2'd0,
    CMP_GEZ = 2'd1,
    CMP_EQZ = 2'd2,
    CMP_NEZ = 2'd3
  } cmp_op_e;

  localparam int CMP_OP_W = 2;

  // Width-independent compare evaluation from the sign and zero flags.
  function automatic logic cmp_eval(input cmp_op_e op, input logic neg, input logic zero);
    logic r;
    case (op)
      CMP_LTZ: r = neg;
      CMP_GEZ: r = ~neg;
      CMP_EQZ: r = zero;
      default: r = ~zero;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pig_cmp_unit.sv
`timescale 1ns/1ps
module pig_cmp_unit
  import pig_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [CMP_OP_W-1:0] op,
  input  logic [DW-1:0]       opnd,
  output logic                result,
  output logic                is_neg,
  output logic                is_zero
);
  // Sign and zero flags brought out as named wires.
  assign is_neg  = opnd[DW-1];
  assign is_zero = ~|opnd;
  assign result  = cmp_eval(cmp_op_e'(op), is_neg, is_zero);
endmodule

// File: rtl/pig_slot_gate.sv
`timescale 1ns/1ps
module pig_slot_gate (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic wreq,
  input  logic cmp_req,
  input  logic gval,
  output logic issued,
  output logic commit,
  output logic wr_en,
  output logic cmp_wr
);
  // A squashed slot still issues, so pipeline timing does not change.
  assign issued = valid;
  assign commit = valid & gval;
  assign wr_en  = wreq & commit;
  assign cmp_wr = cmp_req & commit;

  // R2: no gated write without a commit
  a_r2_wr_within_commit: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (commit && valid && gval));

  // R3: a clear guard squashes the slot but keeps it issued
  a_r3_squash_issued: assert property (@(posedge clk) disable iff (rst)
    (valid && !gval) |-> (issued && !commit && !wr_en));

  // R7: an uncommitted compare never requests a predicate write
  a_r7_squash_no_cmp_wr: assert property (@(posedge clk) disable iff (rst)
    (!valid || !gval) |-> !cmp_wr);
endmodule

// File: rtl/pig_pred_file.sv
`timescale 1ns/1ps
module pig_pred_file #(
  parameter int NPRED = 32,
  parameter int NSLOT = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NSLOT-1:0]                  wr_vld,
  input  logic [NSLOT-1:0][$clog2(NPRED)-1:0] wr_dst,
  input  logic [NSLOT-1:0]                  wr_val,
  input  logic [NSLOT-1:0][$clog2(NPRED)-1:0] rd_idx,
  output logic [NSLOT-1:0]                  rd_val
);
  localparam int PIW = $clog2(NPRED);

  logic [NPRED-1:0]            file_q;
  logic [NPRED-1:0]            eff;
  logic [NSLOT-1:0]            wb_vld;
  logic [NSLOT-1:0][PIW-1:0]   wb_dst;
  logic [NSLOT-1:0]            wb_val;
  logic [NSLOT-1:0]            byp_hit;
  logic                        rst_d;

  // Pending writebacks applied in slot order, so the higher slot wins.
  // Reading eff is the bypass.
  always_comb begin
    eff = file_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (wb_vld[s] && (wb_dst[s] != '0)) eff[wb_dst[s]] = wb_val[s];
    end
    eff[0] = 1'b1;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_rd
    assign rd_val[s] = eff[rd_idx[s]];
    always_comb begin
      byp_hit[s] = 1'b0;
      for (int w = 0; w < NSLOT; w++) begin
        if (wb_vld[w] && (wb_dst[w] == rd_idx[s]) && (wb_dst[w] != '0)) byp_hit[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      file_q <= NPRED'(1);
      wb_vld <= '0;
      wb_dst <= '0;
      wb_val <= '0;
    end else begin
      file_q <= eff;
      wb_vld <= wr_vld;
      wb_dst <= wr_dst;
      wb_val <= wr_val;
    end
  end

  // R1: first cycle out of reset shows only predicate 0 set
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      a_r1_reset_state: assert (file_q == NPRED'(1));
    end
  end

  // R9: predicate 0 never leaves one
  a_r9_p0_pinned: assert property (@(posedge clk) disable iff (rst)
    file_q[0] && eff[0]);

  // R6: a bypassed read agrees with the value the file takes next cycle
  a_r6_bypass_lands: assert property (@(posedge clk) disable iff (rst)
    byp_hit[0] |=> (file_q[$past(rd_idx[0])] == $past(rd_val[0])));

  // R8: the highest slot's writeback is what lands
  a_r8_top_slot_lands: assert property (@(posedge clk) disable iff (rst)
    (wb_vld[NSLOT-1] && (wb_dst[NSLOT-1] != '0))
      |=> (file_q[$past(wb_dst[NSLOT-1])] == $past(wb_val[NSLOT-1])));

  // R10: slot 0 lands when no other slot targets the same bit
  a_r10_slot0_lands: assert property (@(posedge clk) disable iff (rst)
    (wb_vld[0] && (wb_dst[0] != '0) && !(wb_vld[NSLOT-1] && (wb_dst[NSLOT-1] == wb_dst[0])))
      |=> (file_q[$past(wb_dst[0])] == $past(wb_val[0])));
endmodule

// File: rtl/pred_issue_gate.sv
`timescale 1ns/1ps
module pred_issue_gate
  import pig_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int NPRED = 32,
  parameter int DW    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NSLOT-1:0]                  op_valid,
  input  logic [NSLOT-1:0]                  op_wreq,
  input  logic [NSLOT*$clog2(NPRED)-1:0]    op_pidx,
  input  logic [NSLOT-1:0]                  cmp_en,
  input  logic [NSLOT*CMP_OP_W-1:0]         cmp_op,
  input  logic [NSLOT*$clog2(NPRED)-1:0]    cmp_dst,
  input  logic [NSLOT*DW-1:0]               cmp_opnd,
  output logic [NSLOT-1:0]                  slot_issued,
  output logic [NSLOT-1:0]                  slot_commit,
  output logic [NSLOT-1:0]                  slot_wr_en,
  output logic [NSLOT-1:0]                  guard_val
);
  localparam int PIW = $clog2(NPRED);

  logic [NSLOT-1:0]          cmp_res;
  logic [NSLOT-1:0]          cmp_wr;
  logic [NSLOT-1:0]          opnd_neg;
  logic [NSLOT-1:0]          opnd_zero;
  logic [NSLOT-1:0][PIW-1:0] rd_idx;
  logic [NSLOT-1:0][PIW-1:0] wr_dst;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rd_idx[s] = op_pidx[s*PIW +: PIW];
    assign wr_dst[s] = cmp_dst[s*PIW +: PIW];

    pig_cmp_unit #(.DW(DW)) u_cmp (
      .op      (cmp_op[s*CMP_OP_W +: CMP_OP_W]),
      .opnd    (cmp_opnd[s*DW +: DW]),
      .result  (cmp_res[s]),
      .is_neg  (opnd_neg[s]),
      .is_zero (opnd_zero[s])
    );

    pig_slot_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .valid   (op_valid[s]),
      .wreq    (op_wreq[s]),
      .cmp_req (cmp_en[s]),
      .gval    (guard_val[s]),
      .issued  (slot_issued[s]),
      .commit  (slot_commit[s]),
      .wr_en   (slot_wr_en[s]),
      .cmp_wr  (cmp_wr[s])
    );

    // R4: a zero operand is never flagged negative
    a_r4_flags_disjoint: assert property (@(posedge clk) disable iff (rst)
      opnd_zero[s] |-> !opnd_neg[s]);
  end

  pig_pred_file #(.NPRED(NPRED), .NSLOT(NSLOT)) u_pfile (
    .clk    (clk),
    .rst    (rst),
    .wr_vld (cmp_wr),
    .wr_dst (wr_dst),
    .wr_val (cmp_res),
    .rd_idx (rd_idx),
    .rd_val (guard_val)
  );
endmodule

// File: tb/sim_pred_issue_gate.sv
`timescale 1ns/1ps
module sim_pred_issue_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_valid = '0, op_wreq = '0, cmp_en = '0;
  logic [9:0]  op_pidx = '0, cmp_dst = '0;
  logic [3:0]  cmp_op = '0;
  logic [63:0] cmp_opnd = '0;
  logic [1:0]  slot_issued, slot_commit, slot_wr_en, guard_val;

  logic [31:0] mp;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pred_issue_gate u0 (
    .clk, .rst, .op_valid, .op_wreq, .op_pidx, .cmp_en, .cmp_op,
    .cmp_dst, .cmp_opnd, .slot_issued, .slot_commit, .slot_wr_en, .guard_val
  );

  function automatic logic ref_cond(input logic [1:0] op, input logic [31:0] x);
    case (op)
      2'd0: return $signed(x) < 0;
      2'd1: return $signed(x) >= 0;
      2'd2: return x == 32'd0;
      default: return x != 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    op_valid = '0; op_wreq = '0; cmp_en = '0;
    op_pidx = '0; cmp_dst = '0; cmp_op = '0; cmp_opnd = '0;
  endtask

  task automatic set_op(input int s, input logic v, input logic wq, input logic [4:0] g);
    op_valid[s] = v; op_wreq[s] = wq; op_pidx[s*5 +: 5] = g;
  endtask

  task automatic set_cmp(input int s, input logic [4:0] g, input logic [1:0] op,
                         input logic [4:0] d, input logic [31:0] x);
    op_valid[s] = 1'b1; cmp_en[s] = 1'b1; op_pidx[s*5 +: 5] = g;
    cmp_op[s*2 +: 2] = op; cmp_dst[s*5 +: 5] = d; cmp_opnd[s*32 +: 32] = x;
  endtask

  // Settle, then check every output against the model (R2, R3, R6).
  task automatic look(input string tag);
    #1;
    for (int s = 0; s < 2; s++) begin
      logic g, c;
      g = mp[op_pidx[s*5 +: 5]];
      c = op_valid[s] & g;
      chk($sformatf("%s/R6 slot%0d guard", tag, s), guard_val[s], g);
      chk($sformatf("%s/R2 slot%0d commit", tag, s), slot_commit[s], c);
      chk($sformatf("%s/R2 slot%0d wr_en", tag, s), slot_wr_en[s], op_wreq[s] & c);
      chk($sformatf("%s/R3 slot%0d issued", tag, s), slot_issued[s], op_valid[s]);
    end
  endtask

  // Clock edge: the model takes committed compares, slot 1 last.
  task automatic adv();
    logic [31:0] nx;
    nx = mp;
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      if (op_valid[s] && cmp_en[s] && mp[op_pidx[s*5 +: 5]] && (cmp_dst[s*5 +: 5] != 0))
        nx[cmp_dst[s*5 +: 5]] = ref_cond(cmp_op[s*2 +: 2], cmp_opnd[s*32 +: 32]);
    end
    mp = nx;
    @(negedge clk);
  endtask

  // Force predicate d to value b through slot 0 (compare code 2 is "equals zero").
  task automatic force_bit(input logic [4:0] d, input logic b);
    clr(); set_cmp(0, 5'd0, 2'd2, d, b ? 32'd0 : 32'd1); look("pre"); adv();
  endtask

  initial begin
    #(5 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] vals [8];
    vals[0] = 32'd0;          vals[1] = 32'd1;
    vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000;  vals[5] = 32'd5;
    vals[6] = 32'hFFFF_FF00;  vals[7] = 32'h0001_0000;
    mp = 32'h1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: sweep every index through both slots right after reset
    for (int p = 0; p < 32; p++) begin
      clr(); set_op(0, 1'b1, 1'b1, 5'(p)); set_op(1, 1'b1, 1'b0, 5'(31 - p));
      look("R1");
      chk("R1 reset value", guard_val[0], p == 0);
      adv();
    end

    // R4/R5: every code and operand; the target is preloaded with the opposite value
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 8; k++) begin
        logic [4:0] d;
        logic e;
        d = 5'(1 + ((op * 8 + k) % 31));
        e = ref_cond(2'(op), vals[k]);
        force_bit(d, ~e);
        clr(); set_cmp(1, 5'd0, 2'(op), d, vals[k]); look("R4"); adv();
        clr(); set_op(0, 1'b1, 1'b1, d); look("R5");
        chk(e ? "R4 set" : "R5 clear", guard_val[0], e);
        adv();
      end
    end

    // R7: squashed compares (guard clear, then slot invalid) leave the target alone
    force_bit(5'd5, 1'b0);
    force_bit(5'd6, 1'b1);
    clr(); set_cmp(0, 5'd5, 2'd2, 5'd6, 32'd5); look("R7");
    chk("R7 squashed commit", slot_commit[0], 1'b0);
    adv();
    clr(); set_cmp(1, 5'd0, 2'd2, 5'd6, 32'd5); op_valid[1] = 1'b0; look("R7"); adv();
    clr(); set_op(0, 1'b1, 1'b1, 5'd6); look("R7");
    chk("R7 target kept", guard_val[0], 1'b1);
    adv();

    // R3: a valid slot on a clear guard still counts as issued
    clr(); set_op(1, 1'b1, 1'b1, 5'd5); look("R3");
    chk("R3 issued while squashed", slot_issued[1], 1'b1);
    chk("R3 no write while squashed", slot_wr_en[1], 1'b0);
    adv();

    // R8: same-bit conflict, slot 1 wins in both directions
    clr(); set_cmp(0, 5'd0, 2'd2, 5'd7, 32'd0); set_cmp(1, 5'd0, 2'd2, 5'd7, 32'd9);
    look("R8"); adv();
    clr(); set_op(0, 1'b1, 1'b0, 5'd7); look("R8");
    chk("R8 slot1 false wins", guard_val[0], 1'b0);
    adv();
    clr(); set_cmp(0, 5'd0, 2'd3, 5'd7, 32'd0); set_cmp(1, 5'd0, 2'd3, 5'd7, 32'd9);
    look("R8"); adv();
    clr(); set_op(0, 1'b1, 1'b0, 5'd7); look("R8");
    chk("R8 slot1 true wins", guard_val[0], 1'b1);
    adv();

    // R9: writes aimed at predicate 0 are dropped
    clr(); set_cmp(0, 5'd0, 2'd2, 5'd0, 32'd3); set_cmp(1, 5'd0, 2'd0, 5'd0, 32'd3);
    look("R9"); adv();
    clr(); set_op(0, 1'b1, 1'b1, 5'd0); look("R9");
    chk("R9 p0 stays one", guard_val[0], 1'b1);
    chk("R9 p0 commits", slot_commit[0], 1'b1);
    adv();

    // R10: both slots write different bits in one cycle
    force_bit(5'd11, 1'b0);
    force_bit(5'd12, 1'b1);
    clr(); set_cmp(0, 5'd0, 2'd1, 5'd11, 32'd4); set_cmp(1, 5'd0, 2'd0, 5'd12, 32'd4);
    look("R10"); adv();
    clr(); set_op(0, 1'b1, 1'b0, 5'd11); set_op(1, 1'b1, 1'b0, 5'd12); look("R10");
    chk("R10 slot0 bit", guard_val[0], 1'b1);
    chk("R10 slot1 bit", guard_val[1], 1'b0);
    adv();

    // R6: back-to-back chain, each compare guarded by the previous result
    force_bit(5'd9, 1'b0);
    clr(); set_cmp(0, 5'd0, 2'd1, 5'd9, 32'd0); look("R6"); adv();
    clr(); set_cmp(1, 5'd9, 2'd0, 5'd10, 32'hFFFF_FFF0); look("R6");
    chk("R6 next-cycle guard", slot_commit[1], 1'b1);
    adv();
    clr(); set_op(0, 1'b1, 1'b1, 5'd10); look("R6");
    chk("R6 chained result", guard_val[0], 1'b1);
    chk("R6 chained write", slot_wr_en[0], 1'b1);
    adv();

    // Pseudo-random run against the model
    lf = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      clr();
      for (int s = 0; s < 2; s++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        op_valid[s] = lf[0] | lf[1];
        op_wreq[s]  = lf[2];
        cmp_en[s]   = lf[3];
        op_pidx[s*5 +: 5] = lf[4] ? 5'd0 : {2'b00, lf[7:5]};
        cmp_dst[s*5 +: 5] = {2'b00, lf[10:8]};
        cmp_op[s*2 +: 2]  = lf[12:11];
        cmp_opnd[s*32 +: 32] = (lf[15:13] == 3'd0) ? 32'd0 : {lf[16], lf[30:0]};
      end
      look("RND"); adv();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule